// File: doc/BRIEF.md
# ECC Control and Error-Injection Register

This block is one 32-bit control and status register that governs error-correcting-code protection for the three internal RAMs of a flash controller: an ECC buffer, a write FIFO and a read FIFO. A single enable bit arms error capture for all three RAMs. Software can ask for a test fault in any RAM. Writing an inject control bit from 0 to 1 arms exactly one injection. That injection leaves the block as a one-cycle pulse in the cycle the target RAM next accepts a write.

Each RAM reports correctable (single-bit) and non-correctable (double-bit) error events. While capture is enabled, the register turns these events into sticky status flags, and software clears a flag by writing 1 to it. A single interrupt output is raised while any flag is set. The state is cleared only by the cold reset input. No other reset reaches the register.

Top module: `ecc_ctl_reg`

## Requirements
- R1: After cold reset, every field reads 0, `ecc_en` and `irq` are 0, and no injection pulse is asserted.
- R2: Field positions are as follows. Bit 0 is the enable. Bits 1–6 are the inject controls, in the order ECC-buffer single, ECC-buffer double, write-FIFO single, write-FIFO double, read-FIFO single, read-FIFO double. Bits 7–12 are the status flags, in the same RAM/kind order. RAM index 0 is the ECC buffer, 1 is the write FIFO and 2 is the read FIFO. `ecc_en` follows bit 0.
- R3: Bits 31–13 always read 0, and writes to them have no effect.
- R4: A write that changes an inject bit from 0 to 1 produces exactly one pulse on the matching `inj_single`/`inj_double` bit.
- R5: Writing 1 to an inject bit that already holds 1 produces no new injection. A new injection needs the bit to be written to 0 and then to 1.
- R6: Inject bits read back as the value last written, and injection works whatever the state of the enable bit.
- R7: An error event sets its status flag on the next clock edge only while the enable bit is 1. With the enable bit at 0, events are ignored.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If an event and a write-1-to-clear hit the same status bit in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while at least one status bit is set.
- R11: An armed injection stays pending until the target RAM's `ram_wr_accept` is high. The pulse is asserted combinationally in that cycle and the pending injection is then consumed. An accept with nothing pending gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high cold reset; the only reset of the register |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | REG_W | Register write data |
| bus_rdata | output | REG_W | Current register image |
| ram_wr_accept | input | NUM_RAM | Per RAM: a write is accepted this cycle |
| ce_evt | input | NUM_RAM | Per RAM: correctable error event |
| ue_evt | input | NUM_RAM | Per RAM: non-correctable error event |
| inj_single | output | NUM_RAM | Per RAM: inject a single-bit error into this write |
| inj_double | output | NUM_RAM | Per RAM: inject a double-bit error into this write |
| ecc_en | output | 1 | ECC enable for all RAMs |
| irq | output | 1 | Combined error interrupt |

## Verification
The bench builds the block with its defaults: NUM_RAM=3 and REG_W=32. This places all thirteen defined fields at their fixed positions and leaves nineteen reserved bits above them, so every inject/status pair of all three RAMs and the whole reserved range are within reach of the bench. With these values the bench can reach the following cases:
- a write-1-to-clear that collides with a new event;
- a re-armed injection that lands in the same cycle as a consuming accept;
- injection requests made while capture is disabled.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;

    parameter int unsigned ECC_RAMS = 3;

    // Error kind: index within a per-RAM pair of fields.
    typedef enum logic {
        KIND_SINGLE = 1'b0,
        KIND_DOUBLE = 1'b1
    } err_kind_e;

    // Per-RAM pair of signals, one per error kind.
    typedef struct packed {
        logic dbl;
        logic sgl;
    } err_pair_t;

    // Bit position of an inject control.
    function automatic int unsigned inj_pos(input int unsigned ram, input int unsigned kind);
        return 1 + 2 * ram + kind;
    endfunction

    // Bit position of a status flag.
    function automatic int unsigned sts_pos(input int unsigned nram, input int unsigned ram,
                                            input int unsigned kind);
        return 1 + 2 * nram + 2 * ram + kind;
    endfunction

endpackage

// File: rtl/ecc_inj_unit.sv
module ecc_inj_unit (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic accept,
    output logic ctl_q,
    output logic pulse
);
    logic pend_q;
    logic rise;

    assign rise  = wr_stb & wr_bit & ~ctl_q;
    assign pulse = pend_q & accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_stb) ctl_q <= wr_bit;
            pend_q <= (pend_q & ~accept) | rise;
        end
    end
endmodule

// File: rtl/ecc_flag_unit.sv
module ecc_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else if (arm & evt) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/ecc_ctl_reg.sv
module ecc_ctl_reg
    import ecc_ctl_pkg::*;
#(
    parameter int unsigned NUM_RAM = ECC_RAMS,
    parameter int unsigned REG_W   = 32
) (
    input  logic               clk,
    input  logic               cold_rst,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_RAM-1:0] ram_wr_accept,
    input  logic [NUM_RAM-1:0] ce_evt,
    input  logic [NUM_RAM-1:0] ue_evt,
    output logic [NUM_RAM-1:0] inj_single,
    output logic [NUM_RAM-1:0] inj_double,
    output logic               ecc_en,
    output logic               irq
);
    localparam int unsigned FLD  = 2 * NUM_RAM;
    localparam int unsigned USED = 1 + 2 * FLD;

    logic            en_q;
    logic [FLD-1:0]  inj_q;
    logic [FLD-1:0]  pulse;
    logic [FLD-1:0]  sts_q;
    err_pair_t [NUM_RAM-1:0] evt_pair;
    logic            unused_rsvd;

    assign unused_rsvd = ^bus_wdata[REG_W-1:USED];

    always_ff @(posedge clk) begin
        if (cold_rst)    en_q <= 1'b0;
        else if (bus_wr) en_q <= bus_wdata[0];
    end

    for (genvar r = 0; r < NUM_RAM; r++) begin : g_ram
        assign evt_pair[r].sgl = ce_evt[r];
        assign evt_pair[r].dbl = ue_evt[r];
        for (genvar k = 0; k < 2; k++) begin : g_kind
            localparam int unsigned IDX = 2 * r + k;
            ecc_inj_unit u_inj (
                .clk    (clk),
                .rst    (cold_rst),
                .wr_stb (bus_wr),
                .wr_bit (bus_wdata[inj_pos(r, k)]),
                .accept (ram_wr_accept[r]),
                .ctl_q  (inj_q[IDX]),
                .pulse  (pulse[IDX])
            );
            ecc_flag_unit u_flag (
                .clk  (clk),
                .rst  (cold_rst),
                .arm  (en_q),
                .evt  ((k == int'(KIND_DOUBLE)) ? evt_pair[r].dbl : evt_pair[r].sgl),
                .clr  (bus_wr & bus_wdata[sts_pos(NUM_RAM, r, k)]),
                .flag (sts_q[IDX])
            );
        end
        assign inj_single[r] = pulse[2*r];
        assign inj_double[r] = pulse[2*r+1];
    end

    always_comb begin
        bus_rdata              = '0;
        bus_rdata[0]           = en_q;
        bus_rdata[FLD:1]       = inj_q;
        bus_rdata[2*FLD:FLD+1] = sts_q;
    end

    assign ecc_en = en_q;
    assign irq    = |sts_q;
endmodule

// File: rtl/ecc_ctl_reg_chk.sv
module ecc_ctl_reg_chk
    import ecc_ctl_pkg::*;
#(
    parameter int unsigned NUM_RAM = ECC_RAMS,
    parameter int unsigned REG_W   = 32
) (
    input logic               clk,
    input logic               cold_rst,
    input logic               bus_wr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [NUM_RAM-1:0] ram_wr_accept,
    input logic [NUM_RAM-1:0] ce_evt,
    input logic [NUM_RAM-1:0] ue_evt,
    input logic [NUM_RAM-1:0] inj_single,
    input logic [NUM_RAM-1:0] inj_double,
    input logic               ecc_en,
    input logic               irq
);
    localparam int unsigned FLD  = 2 * NUM_RAM;
    localparam int unsigned USED = 1 + 2 * FLD;

    logic unused_chk;
    assign unused_chk = ^bus_wdata[REG_W-1:USED];

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (cold_rst)
        bus_rdata[REG_W-1:USED] == '0);

    a_r10_irq_tracks_flags: assert property (@(posedge clk) disable iff (cold_rst)
        irq == (|bus_rdata[2*FLD:FLD+1]));

    a_r2_enable_output: assert property (@(posedge clk) disable iff (cold_rst)
        ecc_en == bus_rdata[0]);

    for (genvar r = 0; r < NUM_RAM; r++) begin : g_chk
        localparam int unsigned SP = sts_pos(NUM_RAM, r, 0);
        localparam int unsigned DP = sts_pos(NUM_RAM, r, 1);

        a_r11_single_on_accept: assert property (@(posedge clk) disable iff (cold_rst)
            inj_single[r] |-> ram_wr_accept[r]);
        a_r11_double_on_accept: assert property (@(posedge clk) disable iff (cold_rst)
            inj_double[r] |-> ram_wr_accept[r]);

        a_r5_single_one_shot: assert property (@(posedge clk) disable iff (cold_rst)
            inj_single[r] |=> (!inj_single[r] || $past(bus_wr)));
        a_r5_double_one_shot: assert property (@(posedge clk) disable iff (cold_rst)
            inj_double[r] |=> (!inj_double[r] || $past(bus_wr)));

        // R9: a set event dominates a clear write in the same cycle
        a_r9_single_set_wins: assert property (@(posedge clk) disable iff (cold_rst)
            (ecc_en && ce_evt[r]) |=> bus_rdata[SP]);
        a_r9_double_set_wins: assert property (@(posedge clk) disable iff (cold_rst)
            (ecc_en && ue_evt[r]) |=> bus_rdata[DP]);

        a_r8_single_w1c: assert property (@(posedge clk) disable iff (cold_rst)
            (bus_wr && bus_wdata[SP] && !(ecc_en && ce_evt[r])) |=> !bus_rdata[SP]);
        a_r8_double_w1c: assert property (@(posedge clk) disable iff (cold_rst)
            (bus_wr && bus_wdata[DP] && !(ecc_en && ue_evt[r])) |=> !bus_rdata[DP]);

        a_r7_single_gated: assert property (@(posedge clk) disable iff (cold_rst)
            (!bus_rdata[SP] && !(ecc_en && ce_evt[r])) |=> !bus_rdata[SP]);
        a_r7_double_gated: assert property (@(posedge clk) disable iff (cold_rst)
            (!bus_rdata[DP] && !(ecc_en && ue_evt[r])) |=> !bus_rdata[DP]);
    end
endmodule

bind ecc_ctl_reg ecc_ctl_reg_chk #(.NUM_RAM(NUM_RAM), .REG_W(REG_W)) u_chk (
    .clk           (clk),
    .cold_rst      (cold_rst),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .ram_wr_accept (ram_wr_accept),
    .ce_evt        (ce_evt),
    .ue_evt        (ue_evt),
    .inj_single    (inj_single),
    .inj_double    (inj_double),
    .ecc_en        (ecc_en),
    .irq           (irq)
);

// File: tb/tb_ecc_ctl_reg.sv
module tb_ecc_ctl_reg;
    localparam int NR  = 3;
    localparam int FLD = 2 * NR;

    logic          clk = 1'b0;
    logic          cold_rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NR-1:0] ram_wr_accept = '0, ce_evt = '0, ue_evt = '0;
    logic [NR-1:0] inj_single, inj_double;
    logic          ecc_en, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model of the register
    logic           m_en;
    logic [FLD-1:0] m_inj, m_pend, m_sts;

    always #10 clk = ~clk;

    ecc_ctl_reg dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [FLD-1:0] spread(input logic [NR-1:0] s, input logic [NR-1:0] d);
        logic [FLD-1:0] v;
        for (int r = 0; r < NR; r++) begin
            v[2*r]   = s[r];
            v[2*r+1] = d[r];
        end
        return v;
    endfunction

    function automatic logic [31:0] image();
        return {19'd0, m_sts, m_inj, m_en};
    endfunction

    // one bus cycle: drive at negedge, compare, advance model at posedge
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic [NR-1:0] acc,
                       input logic [NR-1:0] ce, input logic [NR-1:0] ue, input string tag);
        logic [FLD-1:0] pulse, rise, clr, setv;
        @(negedge clk);
        bus_wr = wr; bus_wdata = wd; ram_wr_accept = acc; ce_evt = ce; ue_evt = ue;
        #1;
        pulse = m_pend & spread(acc, acc);
        chk({tag, " rdata"}, bus_rdata, image());
        chk({tag, " inj"}, {26'd0, spread(inj_single, inj_double)}, {26'd0, pulse});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, |m_sts});
        chk({tag, " ecc_en"}, {31'd0, ecc_en}, {31'd0, m_en});
        rise = wr ? (wd[FLD:1] & ~m_inj) : '0;
        clr  = wr ? wd[2*FLD:FLD+1] : '0;
        setv = m_en ? spread(ce, ue) : '0;
        @(posedge clk);
        m_pend = (m_pend & ~pulse) | rise;
        m_sts  = setv | (m_sts & ~clr);
        if (wr) begin
            m_inj = wd[FLD:1];
            m_en  = wd[0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        m_en = 0; m_inj = '0; m_pend = '0; m_sts = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) cold_rst = 1'b0;
        // R1: reset state
        cyc(0, 0, 3'b111, 0, 0, "R1 reset");
        chk("R1 rdata literal", bus_rdata, 32'h0);

        // R2/R3: full write, upper bits must not stick
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, "R2 R3 write all");
        cyc(0, 0, 0, 0, 0, "R3 readback");
        chk("R2 R3 literal image", bus_rdata, 32'h0000_007F);
        // R4 R11: all six pending injections fire on accept, then consumed
        cyc(0, 0, 3'b111, 0, 0, "R4 R11 fire");
        cyc(0, 0, 3'b111, 0, 0, "R4 consumed");
        // R5: holding at 1 gives no injection
        cyc(1, 32'h0000_007F, 0, 0, 0, "R5 rewrite one");
        cyc(0, 0, 3'b111, 0, 0, "R5 no reinject");
        // R6: clear enable, re-arm write-FIFO single (bit 3) via 0 then 1
        cyc(1, 32'h0000_0000, 0, 0, 0, "R6 clear");
        cyc(1, 32'h0000_0008, 0, 0, 0, "R6 arm wfifo single");
        cyc(0, 0, 3'b101, 0, 0, "R11 wrong ram accept");
        cyc(0, 0, 3'b010, 0, 0, "R6 R11 inject while disabled");
        // R7: events ignored while disabled
        cyc(0, 0, 0, 3'b111, 3'b111, "R7 disabled event");
        cyc(0, 0, 0, 0, 0, "R7 check");
        chk("R7 no flags", bus_rdata & 32'h1F80, 32'h0);
        // R7/R10: enable, read-FIFO double event -> bit 12
        cyc(1, 32'h1, 0, 0, 0, "R2 enable");
        cyc(0, 0, 0, 0, 3'b100, "R7 event");
        cyc(0, 0, 0, 0, 0, "R7 R10 check");
        chk("R7 rfifo double bit12", bus_rdata, 32'h0000_1001);
        // R8: writing 0 leaves flag, writing 1 clears
        cyc(1, 32'h1, 0, 0, 0, "R8 write zero");
        cyc(1, 32'h1001, 0, 0, 0, "R8 w1c");
        cyc(0, 0, 0, 0, 0, "R8 R10 cleared");
        // R9: event and clear collide on ECC-buffer single (bit 7)
        cyc(0, 0, 0, 3'b001, 0, "R9 set");
        cyc(1, 32'h81, 0, 3'b001, 0, "R9 collide");
        cyc(0, 0, 0, 0, 0, "R9 check");
        chk("R9 set wins", bus_rdata, 32'h0000_0081);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic wr;
            wr = ($urandom % 10) < 3;
            cyc(wr, $urandom, NR'($urandom), (($urandom % 5) == 0) ? NR'($urandom) : '0,
                (($urandom % 5) == 0) ? NR'($urandom) : '0, "R4 R5 R6 R8 R9 R10 R11 random");
        end

        // R1: cold reset mid-run clears everything
        @(negedge clk) cold_rst = 1'b1;
        @(negedge clk) cold_rst = 1'b0;
        m_en = 0; m_inj = '0; m_pend = '0; m_sts = '0;
        cyc(0, 0, 3'b111, 0, 0, "R1 cold reset again");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule